// File: doc/BRIEF.md
# RAW hazard stall interlock

This block decides, every cycle, whether a five-stage in-order pipeline (IF, ID, EX, MEM, WB) without operand forwarding must pause. It compares the source register indices of the instruction held in ID against the destination indices of the older instructions in EX and MEM. If an operand is still being produced, it freezes the program counter and the IF/ID register and sends a bubble into EX. The register file writes only in WB, and every operand is read in ID. Because of that ordering, only read-after-write dependencies can cause hazards. Write-after-read and write-after-write dependencies are ignored.

The parameter `WRITE_THROUGH` describes the register file. When it is 1, a read in the same cycle as a write returns the new value, so the instruction in WB never causes a hazard. When it is 0, a read returns the old value, so WB is compared as well and the hazard window grows by one cycle. The outputs depend only on the current pipeline-register contents and contain no state. The clock and reset inputs serve only the built-in checks.

Top module: `raw_hazard_interlock`

## Requirements
- R1: A used source in ID that equals the EX destination stalls, when the EX write flag is 1 and that destination is nonzero.
- R2: A used source in ID that equals the MEM destination stalls, when the MEM write flag is 1 and that destination is nonzero.
- R3: With WRITE_THROUGH=1 a match against WB never stalls. With WRITE_THROUGH=0, a used source that equals a nonzero WB destination with the WB write flag set does stall.
- R4: A destination index of 0 never causes a stall, whatever its write flag.
- R5: A source whose used flag is 0 never causes a stall, whatever its index.
- R6: A stage whose write flag is 0 never causes a stall. This covers write-after-write and write-after-read pairs, which never stall.
- R7: The PC hold, IF/ID hold and EX bubble outputs are all 1 in a stall cycle and all 0 otherwise. They change in the same cycle as the inputs.
- R8: A consumer with k unrelated instructions between it and its producer stalls for max(0, W-k) cycles, where W=2 when WRITE_THROUGH=1 and W=3 when WRITE_THROUGH=0.
- R9: Either source alone is enough to stall. With two producers, the stall lasts as long as the later producer needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| id_src_a | input | REG_W | First source index of the ID instruction |
| id_src_a_en | input | 1 | First source is read |
| id_src_b | input | REG_W | Second source index of the ID instruction |
| id_src_b_en | input | 1 | Second source is read |
| ex_dst | input | REG_W | Destination index in EX |
| ex_wr | input | 1 | EX instruction writes a register |
| mem_dst | input | REG_W | Destination index in MEM |
| mem_wr | input | 1 | MEM instruction writes a register |
| wb_dst | input | REG_W | Destination index in WB |
| wb_wr | input | 1 | WB instruction writes a register |
| hold_pc | output | 1 | Keep the program counter |
| hold_fetch | output | 1 | Keep the IF/ID register |
| bubble_ex | output | 1 | Load a write-free NOP into EX |

## Verification
The consecutive-stall check assumes that the surrounding pipeline obeys the block. During a stall, ID holds, a write-free bubble enters EX, and the older stages shift toward WB. Under that behaviour, no stall run can exceed the hazard window. The stimulus comes from a small pipeline model in the bench. The model advances by the stall decision computed from the requirements, so the stage contents always form a sequence a real pipeline could produce. Each design variant runs with its own model, and the idle variant sees all-zero inputs.

// File: rtl/raw_ilk_pkg.sv
package raw_ilk_pkg;

   // Positions of the older stages in the packed producer arrays.
   localparam int STAGE_EX     = 0;
   localparam int STAGE_MEM    = 1;
   localparam int STAGE_WB     = 2;
   localparam int OLDER_STAGES = 3;

   // Number of cycles a back-to-back consumer must wait.
   function automatic int window_depth(input int write_through);
      return (write_through != 0) ? 2 : 3;
   endfunction

   // Bit mask of the stages that can still hold an unwritten result.
   function automatic logic [OLDER_STAGES-1:0] live_mask(input int write_through);
      logic [OLDER_STAGES-1:0] m;
      m = '0;
      m[STAGE_EX]  = 1'b1;
      m[STAGE_MEM] = 1'b1;
      m[STAGE_WB]  = (write_through == 0);
      return m;
   endfunction

endpackage

// File: rtl/raw_ilk_match.sv
module raw_ilk_match #(
   parameter int REG_W = 5
) (
   input  logic [REG_W-1:0] src,
   input  logic             src_en,
   input  logic [REG_W-1:0] dst,
   input  logic             dst_wr,
   output logic             hit
);

   if (REG_W < 1) begin : g_bad_width
      $error("raw_ilk_match: REG_W must be at least 1");
   end

   logic producer_live;

   // Index zero is the hard-wired zero register and never carries a result.
   assign producer_live = dst_wr && (dst != '0);
   assign hit           = producer_live && src_en && (src == dst);

endmodule

// File: rtl/raw_ilk_window.sv
module raw_ilk_window
   import raw_ilk_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter int WRITE_THROUGH = 1
) (
   input  logic [REG_W-1:0]                    src_a,
   input  logic                                src_a_en,
   input  logic [REG_W-1:0]                    src_b,
   input  logic                                src_b_en,
   input  logic [OLDER_STAGES-1:0][REG_W-1:0]  dst,
   input  logic [OLDER_STAGES-1:0]             dst_wr,
   output logic                                hazard
);

   localparam logic [OLDER_STAGES-1:0] LIVE = live_mask(WRITE_THROUGH);

   logic [OLDER_STAGES-1:0] hit_a;
   logic [OLDER_STAGES-1:0] hit_b;
   logic [OLDER_STAGES-1:0] stage_hit;

   for (genvar s = 0; s < OLDER_STAGES; s++) begin : g_stage
      raw_ilk_match #(.REG_W(REG_W)) u_cmp_a (
         .src    (src_a),
         .src_en (src_a_en),
         .dst    (dst[s]),
         .dst_wr (dst_wr[s]),
         .hit    (hit_a[s])
      );
      raw_ilk_match #(.REG_W(REG_W)) u_cmp_b (
         .src    (src_b),
         .src_en (src_b_en),
         .dst    (dst[s]),
         .dst_wr (dst_wr[s]),
         .hit    (hit_b[s])
      );
      assign stage_hit[s] = hit_a[s] | hit_b[s];
   end

   // A pass-through register file hides the WB stage; its mask bit is clear.
   assign hazard = |(stage_hit & LIVE);

endmodule

// File: rtl/raw_ilk_ctrl.sv
module raw_ilk_ctrl #(
   parameter int WINDOW = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hazard,
   output logic hold_pc,
   output logic hold_fetch,
   output logic bubble_ex
);

   if (WINDOW < 1 || WINDOW > 3) begin : g_bad_window
      $error("raw_ilk_ctrl: WINDOW must lie in 1..3");
   end

   localparam logic [1:0] WIN_L = 2'(WINDOW);

   assign hold_pc    = hazard;
   assign hold_fetch = hazard;
   assign bubble_ex  = hazard;

   // Length of the current stall run, used only by the check below.
   logic [1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 2'd0;
      end else if (hazard) begin
         run_q <= (run_q == 2'd3) ? run_q : run_q + 2'd1;
      end else begin
         run_q <= 2'd0;
      end
   end

   // R8
   stall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hazard |-> (run_q < WIN_L));

endmodule

// File: rtl/raw_hazard_interlock.sv
module raw_hazard_interlock
   import raw_ilk_pkg::*;
#(
   parameter int REG_W         = 5,
   parameter int WRITE_THROUGH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_src_a,
   input  logic             id_src_a_en,
   input  logic [REG_W-1:0] id_src_b,
   input  logic             id_src_b_en,
   input  logic [REG_W-1:0] ex_dst,
   input  logic             ex_wr,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic [REG_W-1:0] wb_dst,
   input  logic             wb_wr,
   output logic             hold_pc,
   output logic             hold_fetch,
   output logic             bubble_ex
);

   if (REG_W < 1 || REG_W > 16) begin : g_bad_reg_w
      $error("raw_hazard_interlock: REG_W must lie in 1..16");
   end
   if (WRITE_THROUGH != 0 && WRITE_THROUGH != 1) begin : g_bad_wt
      $error("raw_hazard_interlock: WRITE_THROUGH must be 0 or 1");
   end

   localparam int WINDOW = window_depth(WRITE_THROUGH);

   logic [OLDER_STAGES-1:0][REG_W-1:0] older_dst;
   logic [OLDER_STAGES-1:0]            older_wr;
   logic                               hazard;

   assign older_dst[STAGE_EX]  = ex_dst;
   assign older_dst[STAGE_MEM] = mem_dst;
   assign older_dst[STAGE_WB]  = wb_dst;
   assign older_wr[STAGE_EX]   = ex_wr;
   assign older_wr[STAGE_MEM]  = mem_wr;
   assign older_wr[STAGE_WB]   = wb_wr;

   raw_ilk_window #(
      .REG_W         (REG_W),
      .WRITE_THROUGH (WRITE_THROUGH)
   ) u_window (
      .src_a    (id_src_a),
      .src_a_en (id_src_a_en),
      .src_b    (id_src_b),
      .src_b_en (id_src_b_en),
      .dst      (older_dst),
      .dst_wr   (older_wr),
      .hazard   (hazard)
   );

   raw_ilk_ctrl #(.WINDOW(WINDOW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .hazard     (hazard),
      .hold_pc    (hold_pc),
      .hold_fetch (hold_fetch),
      .bubble_ex  (bubble_ex)
   );

   // R1
   ex_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_wr && ex_dst != '0 && id_src_a_en && id_src_a == ex_dst) |-> hold_pc);

   // R2
   mem_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && mem_dst != '0 && id_src_b_en && id_src_b == mem_dst) |-> bubble_ex);

   // R4
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ex_dst == '0) && (mem_dst == '0) && (wb_dst == '0)) |-> !hold_fetch);

   // R5
   unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_src_a_en && !id_src_b_en) |-> !hold_pc);

   // R6
   no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ex_wr && !mem_wr && !wb_wr) |-> !bubble_ex);

   if (WRITE_THROUGH != 0) begin : g_wb_hidden
      // R3
      wb_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ex_wr && !mem_wr) |-> !hold_pc);
   end else begin : g_wb_seen
      // R3
      wb_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wb_wr && wb_dst != '0 && id_src_a_en && id_src_a == wb_dst) |-> hold_pc);
   end

endmodule

// File: tb/raw_hazard_interlock_test.sv
`timescale 1ns/1ps
module raw_hazard_interlock_test;

   typedef struct packed {
      logic [4:0] rd;
      logic       wr;
      logic [4:0] ra;
      logic       ra_en;
      logic [4:0] rb;
      logic       rb_en;
   } ins_t;

   typedef struct {
      int    v;
      logic  hold;
      string tag;
   } item_t;

   localparam ins_t NOP = '0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // Per-variant stimulus: variant 0 passes writes through, variant 1 does not.
   ins_t s_id[2], s_ex[2], s_mem[2], s_wb[2];
   logic h_pc[2], h_if[2], h_bx[2];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   item_t exp_q[$];
   ins_t prog[$];

   raw_hazard_interlock #(.REG_W(5), .WRITE_THROUGH(1)) uut (
      .clk(clk), .rst_n(rst_n),
      .id_src_a(s_id[0].ra), .id_src_a_en(s_id[0].ra_en),
      .id_src_b(s_id[0].rb), .id_src_b_en(s_id[0].rb_en),
      .ex_dst(s_ex[0].rd), .ex_wr(s_ex[0].wr),
      .mem_dst(s_mem[0].rd), .mem_wr(s_mem[0].wr),
      .wb_dst(s_wb[0].rd), .wb_wr(s_wb[0].wr),
      .hold_pc(h_pc[0]), .hold_fetch(h_if[0]), .bubble_ex(h_bx[0])
   );

   raw_hazard_interlock #(.REG_W(5), .WRITE_THROUGH(0)) uut_wb (
      .clk(clk), .rst_n(rst_n),
      .id_src_a(s_id[1].ra), .id_src_a_en(s_id[1].ra_en),
      .id_src_b(s_id[1].rb), .id_src_b_en(s_id[1].rb_en),
      .ex_dst(s_ex[1].rd), .ex_wr(s_ex[1].wr),
      .mem_dst(s_mem[1].rd), .mem_wr(s_mem[1].wr),
      .wb_dst(s_wb[1].rd), .wb_wr(s_wb[1].wr),
      .hold_pc(h_pc[1]), .hold_fetch(h_if[1]), .bubble_ex(h_bx[1])
   );

   function automatic ins_t mk(input int rd, input bit wr, input int ra, input bit ra_en,
                               input int rb, input bit rb_en);
      ins_t i;
      i.rd = 5'(rd); i.wr = wr; i.ra = 5'(ra); i.ra_en = ra_en;
      i.rb = 5'(rb); i.rb_en = rb_en;
      return i;
   endfunction

   // A producer blocks the reader when it writes a nonzero register the reader uses.
   function automatic bit blocks(input ins_t rdr, input ins_t p);
      return p.wr && (p.rd != 5'd0) &&
             ((rdr.ra_en && rdr.ra == p.rd) || (rdr.rb_en && rdr.rb == p.rd));
   endfunction

   function automatic logic exp_hold(input int v, input ins_t id, input ins_t ex,
                                     input ins_t mem, input ins_t wb);
      return blocks(id, ex) || blocks(id, mem) || (v == 1 && blocks(id, wb));
   endfunction

   // Monitor: pops expectations and compares all three controls (R7).
   always @(negedge clk) begin
      while (exp_q.size() != 0) begin
         item_t it;
         logic [2:0] act;
         it  = exp_q.pop_front();
         act = {h_pc[it.v], h_if[it.v], h_bx[it.v]};
         checks++;
         if (act !== {3{it.hold}}) begin
            fails++;
            $display("FAIL %s/R7 variant %0d: controls=%b expected=%b",
                     it.tag, it.v, act, {3{it.hold}});
         end
      end
   end

   task automatic drive(input int v, input ins_t id, input ins_t ex, input ins_t mem,
                        input ins_t wb);
      for (int k = 0; k < 2; k++) begin
         s_id[k] = (k == v) ? id : NOP;
         s_ex[k] = (k == v) ? ex : NOP;
         s_mem[k] = (k == v) ? mem : NOP;
         s_wb[k] = (k == v) ? wb : NOP;
      end
   endtask

   // Runs prog through a pipeline model and counts stall cycles of entry 'watch'.
   task automatic run_prog(input int v, input int watch, input int exp_n, input string tag);
      ins_t id = NOP, ex = NOP, mem = NOP, wb = NOP;
      int id_idx = -1;
      int p = 0;
      int seen = 0;
      item_t it;
      for (int cyc = 0; cyc < prog.size() * 4 + 8; cyc++) begin
         logic e;
         drive(v, id, ex, mem, wb);
         e = exp_hold(v, id, ex, mem, wb);
         it.v = v; it.hold = e; it.tag = tag;
         exp_q.push_back(it);
         if (e && id_idx == watch) seen++;
         @(posedge clk);
         #1;
         wb  = mem;
         mem = ex;
         if (e) begin
            ex = NOP;
         end else begin
            ex = id;
            if (p < prog.size()) begin
               id = prog[p]; id_idx = p;
            end else begin
               id = NOP; id_idx = -1;
            end
            p++;
         end
      end
      drive(v, NOP, NOP, NOP, NOP);
      @(posedge clk);
      #1;
      checks++;
      if (seen != exp_n) begin
         fails++;
         $display("FAIL %s variant %0d: stall cycles=%0d expected=%0d", tag, v, seen, exp_n);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stimulus
      item_t it;
      ins_t P5, C5;
      drive(0, NOP, NOP, NOP, NOP);
      repeat (3) @(posedge clk);
      #1;
      // Reset state: idle pipeline, no stall on either variant (R7).
      for (int v = 0; v < 2; v++) begin
         it.v = v; it.hold = 1'b0; it.tag = "reset";
         exp_q.push_back(it);
      end
      @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      P5 = mk(5, 1, 1, 1, 2, 1);
      C5 = mk(8, 1, 5, 1, 9, 1);

      // R1 / R8: adjacent consumer, pass-through file waits two cycles.
      prog = {P5, C5};                 run_prog(0, 1, 2, "R1");
      // R2: one filler, MEM match only.
      prog = {P5, NOP, C5};            run_prog(0, 2, 1, "R2");
      // R3: two fillers, WB hidden by pass-through.
      prog = {P5, NOP, NOP, C5};       run_prog(0, 3, 0, "R3");
      // R8: three fillers, never a hazard.
      prog = {P5, NOP, NOP, NOP, C5};  run_prog(0, 4, 0, "R8");
      // R8: old-value register file widens the window to three.
      prog = {P5, C5};                 run_prog(1, 1, 3, "R8");
      prog = {P5, NOP, C5};            run_prog(1, 2, 2, "R2");
      // R3: WB match stalls once when the file returns the old value.
      prog = {P5, NOP, NOP, C5};       run_prog(1, 3, 1, "R3");
      prog = {P5, NOP, NOP, NOP, C5};  run_prog(1, 4, 0, "R8");
      // R9: only the second source depends.
      prog = {mk(7, 1, 1, 1, 1, 1), mk(3, 1, 4, 1, 7, 1)};
      run_prog(0, 1, 2, "R9");
      // R4: writes to register 0 never block.
      prog = {mk(0, 1, 1, 1, 2, 1), mk(3, 1, 0, 1, 0, 1)};
      run_prog(0, 1, 0, "R4");
      run_prog(1, 1, 0, "R4");
      // R5: indices match but neither source is read.
      prog = {mk(6, 1, 1, 1, 2, 1), mk(3, 1, 6, 0, 6, 0)};
      run_prog(0, 1, 0, "R5");
      // R6: older instruction does not write (read-after-read / WAR shape).
      prog = {mk(6, 0, 1, 1, 2, 1), mk(1, 1, 6, 1, 6, 1)};
      run_prog(1, 1, 0, "R6");
      // R6: write-after-write without a read of that register.
      prog = {mk(2, 1, 1, 1, 3, 1), mk(2, 1, 9, 1, 10, 1)};
      run_prog(1, 1, 0, "R6");
      // R9: two producers, later one sets the stall length.
      prog = {mk(3, 1, 1, 1, 1, 1), mk(4, 1, 1, 1, 1, 1), mk(5, 1, 3, 1, 4, 1)};
      run_prog(0, 2, 2, "R9");
      run_prog(1, 2, 3, "R9");

      repeat (2) @(posedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule